// File: doc/BRIEF.md
# Full-Duplex Serial Master with Programmable Baud Divider

This block is a byte-wide serial peripheral master whose clock comes from a reloadable 12-bit divider rather than a fixed prescaler. Writing a byte to the holding register starts a frame. The block then drives the serial clock out. It launches eight bits on the data-out line and captures eight bits from the data-in line. All four clock polarity and phase combinations are supported, and a control bit picks the bit order.

The transmitter and receiver have their own enables. With the transmitter off, the data-out line stays high. With the receiver off, the read side is left alone. Only master operation exists: the clock is always generated inside the block. The host reads a received byte from the read-data output and acknowledges it with a read strobe.

Top module: `spim_engine`

## Requirements
- R1: The serial clock idles at the level of `cpol` whenever no frame is in progress, including while the block is disabled.
- R2: Each serial clock half-period lasts `div_val`+1 system clocks, with `div_val` ranging over 0..4095. The serial clock rate is therefore f/(2(`div_val`+1)).
- R3: A frame has 16 serial clock edges. `busy` rises on the clock edge that accepts a write and stays high for exactly 16(`div_val`+1) system clocks.
- R4: With `cpha`=0, the first data bit is on `mosi` as soon as the frame starts. Edges 1, 3, 5, … (the leading edges) sample `miso`, and the trailing edges move `mosi` to the next bit.
- R5: With `cpha`=1, the leading edges (1, 3, …) move `mosi` to its next bit, and the trailing edges (2, 4, …) sample `miso`.
- R6: With `lsb_first`=0, bit 7 goes first in both directions. With `lsb_first`=1, bit 0 goes first in both directions.
- R7: A write (`wr_stb`) is accepted only while the block is enabled and idle. A write during a frame is ignored: it changes neither the bits being sent nor the frame length, and it starts no frame afterwards.
- R8: When a frame ends with `rx_en`=1, the captured byte appears on `rd_data` and `rx_done` is set. With `rx_en`=0, both keep their previous values.
- R9: A `rd_stb` pulse clears `rx_done`, unless a frame ends in that same cycle, in which case the flag is set.
- R10: With `tx_en`=0, `mosi` is held at 1, so the frame sends the byte 0xFF.
- R11: With both `tx_en` and `rx_en` at 0, the block is disabled: writes are ignored and any frame in progress stops, with `busy` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_val | input | 12 | Baud divider value N; half-period is N+1 clocks |
| cpol | input | 1 | Clock polarity (idle level) |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing |
| lsb_first | input | 1 | 1 sends and receives bit 0 first |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Read acknowledge, clears `rx_done` |
| rd_data | output | 8 | Last received byte |
| busy | output | 1 | Frame in progress |
| rx_done | output | 1 | Receive-complete flag |
| sck | output | 1 | Serial clock out |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench models a slave in every mode. The slave changes `miso` only after the master's sample edge. A design that samples on the wrong edge therefore captures a shifted or duplicated byte, and one with reversed bit order mirrors both the captured and the sent byte. Half-periods are timed edge by edge at divider values 0, 1, 2, 4 and 4095. This catches an off-by-one in the reload or a counter that truncates the 12-bit value. The bench also writes during a frame and writes while the block is disabled. A design that accepts such a write corrupts the bits sent or starts an extra frame. Finally, the bench runs frames with each direction switched off. A faulty design then drives data onto `mosi` or overwrites `rd_data`.

// File: rtl/spim_pkg.sv
// Shared widths for the serial master engine.
// Assumes byte frames and a 12-bit divider; both may be overridden by parameters.
package spim_pkg;
    localparam int SPIM_DATA_W = 8;
    localparam int SPIM_DIV_W  = 12;
endpackage

// File: rtl/spim_baud.sv
// Baud tick generator: while run is high, pulses tick once every div+1 clocks.
// Assumes div is held stable during a frame; the count restarts from 0 whenever run is low.
module spim_baud #(
    parameter int DIV_W = spim_pkg::SPIM_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Tick fires on the last count of each half-period.
    assign tick = run && (cnt == div);

    // Count up to div, then wrap to zero; held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
// Frame sequencer: counts 2*DATA_W clock edges, toggles the serial clock,
// shifts the transmit byte on setup edges and captures data-in on sample edges.
// Assumes tick comes from spim_baud and start only arrives while idle and enabled.
module spim_shifter #(
    parameter int DATA_W = spim_pkg::SPIM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_done,
    output logic              frame_end
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES + 1);

    logic [EW-1:0]     edge_cnt;
    logic [EW-1:0]     edge_nxt;
    logic              toggle;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] rx_nxt;
    logic              is_lead;
    logic              is_sample;
    logic              is_setup;
    logic              do_shift;

    // Classify the upcoming serial clock edge.
    always_comb begin
        edge_nxt  = edge_cnt + 1'b1;
        is_lead   = edge_nxt[0];
        is_sample = tick && (cpha ? !is_lead : is_lead);
        is_setup  = tick && (cpha ? is_lead : !is_lead);
        do_shift  = is_setup && !(cpha && edge_nxt == EW'(1)) && (edge_nxt != EW'(EDGES));
        rx_nxt    = lsb_first ? {miso, rx_sr[DATA_W-1:1]} : {rx_sr[DATA_W-2:0], miso};
        frame_end = tick && enable && (edge_nxt == EW'(EDGES));
    end

    assign sck  = cpol ^ toggle;
    assign mosi = tx_en ? (lsb_first ? tx_sr[0] : tx_sr[DATA_W-1]) : 1'b1;

    // Frame state: start, edge counting, shifting and abort on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            edge_cnt <= '0;
            toggle   <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
        end else if (!enable) begin
            busy     <= 1'b0;
            edge_cnt <= '0;
            toggle   <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            edge_cnt <= '0;
            toggle   <= 1'b0;
            tx_sr    <= wr_data;
            rx_sr    <= '0;
        end else if (tick) begin
            edge_cnt <= edge_nxt;
            toggle   <= ~toggle;
            if (do_shift)
                tx_sr <= lsb_first ? {1'b0, tx_sr[DATA_W-1:1]} : {tx_sr[DATA_W-2:0], 1'b0};
            if (is_sample)
                rx_sr <= rx_nxt;
            if (frame_end)
                busy <= 1'b0;
        end
    end

    // Receive result and completion flag; a frame end wins over a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rx_done <= 1'b0;
        end else if (frame_end && rx_en) begin
            rd_data <= is_sample ? rx_nxt : rx_sr;
            rx_done <= 1'b1;
        end else if (rd_stb) begin
            rx_done <= 1'b0;
        end
    end

    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);
    p_sck_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sck != $past(sck)) |-> $past(tick));
    p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(enable)) |-> $past(edge_cnt) == EW'(EDGES - 1));
    p_done_needs_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(rx_en));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frame_end) |=> !rx_done);
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);
endmodule

// File: rtl/spim_engine.sv
// Top of the serial master: glues the baud divider to the frame sequencer and
// gates writes so that only an enabled, idle engine starts a frame.
// Assumes mode bits and divider stay constant while busy is high.
module spim_engine #(
    parameter int DATA_W = spim_pkg::SPIM_DATA_W,
    parameter int DIV_W  = spim_pkg::SPIM_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              rx_done,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    logic enable;
    logic start;
    logic tick;
    logic frame_end;

    // Accept a write only while enabled and idle.
    assign enable = tx_en || rx_en;
    assign start  = wr_stb && enable && !busy;

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div_val),
        .tick  (tick)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (start),
        .tick      (tick),
        .cpol      (cpol),
        .cpha      (cpha),
        .lsb_first (lsb_first),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .miso      (miso),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .rd_data   (rd_data),
        .rx_done   (rx_done),
        .frame_end (frame_end)
    );

    p_ignore_busy_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && !frame_end && enable) |=> busy);
endmodule

// File: tb/test_spim_engine.sv
// Scoreboard bench: the driver queues the expected bytes for each frame, a bus-model
// slave answers on miso, and a monitor compares results when busy falls.
module test_spim_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_val = '0;
    logic        cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        busy, rx_done, sck, mosi, miso;

    typedef struct {
        logic [7:0] mo;
        logic [7:0] mi;
        bit         rx;
    } exp_t;
    exp_t q[$];

    int tests = 0, fails = 0;
    logic [7:0] slave_byte = '0;
    logic [7:0] last_rx = '0;
    int edges = 0;

    always #4 clk = ~clk;

    spim_engine i_spim_engine (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .tx_en(tx_en), .rx_en(rx_en), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .busy(busy),
        .rx_done(rx_done), .sck(sck), .mosi(mosi), .miso(miso)
    );

    // Slave model: bit index advances only after the master's sample edges.
    function automatic int slave_idx(int e, logic ph);
        int k;
        k = ph ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        return (k > 7) ? 7 : k;
    endfunction
    assign miso = lsb_first ? slave_byte[slave_idx(edges, cpha)]
                            : slave_byte[7 - slave_idx(edges, cpha)];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [7:0] tx, input logic [7:0] slv);
        exp_t e;
        slave_byte = slv;
        e.mo = tx_en ? tx : 8'hFF;
        e.rx = rx_en;
        e.mi = rx_en ? slv : last_rx;
        if (rx_en) last_rx = slv;
        q.push_back(e);
        @(negedge clk); wr_stb = 1'b1; wr_data = tx;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Monitor: times edges, captures mosi on sample edges, scores at frame end.
    logic [7:0] cap;
    logic prev_sck = 1'b0, prev_busy = 1'b0;
    int cyc = 0, bcyc = 0;
    bit per_ok = 1'b1;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (busy && !prev_busy) begin
                edges = 0; cyc = 0; bcyc = 0; per_ok = 1'b1; cap = '0;
            end else if (prev_busy) begin
                cyc++; bcyc++;
                if (sck != prev_sck) begin
                    edges++;
                    if (cyc != int'(div_val) + 1) per_ok = 1'b0;
                    cyc = 0;
                    if (cpha ? (edges % 2 == 0) : (edges % 2 == 1)) begin
                        if (lsb_first) cap[(edges - 1) / 2] = mosi;
                        else           cap[7 - (edges - 1) / 2] = mosi;
                    end
                end
                if (!busy) begin
                    exp_t e;
                    chk(per_ok, "R2 half-period", 0, 0);
                    chk(bcyc == 16 * (int'(div_val) + 1), "R3 busy length", bcyc, 16 * (int'(div_val) + 1));
                    chk(edges == 16, "R3 edge count", edges, 16);
                    if (q.size() == 0) begin
                        chk(1'b0, "R7 unexpected frame", 1, 0);
                    end else begin
                        e = q.pop_front();
                        chk(cap == e.mo, "R4 R5 R6 R10 mosi byte", cap, e.mo);
                        chk(rd_data == e.mi, "R4 R5 R6 R8 rd_data", rd_data, e.mi);
                        chk(rx_done == e.rx, "R8 rx_done", rx_done, e.rx);
                    end
                end
            end
        end
        prev_sck = sck;
        prev_busy = busy;
    end

    initial begin
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rx_done && rd_data == 8'h00, "R1 reset state", {busy, rx_done, rd_data}, 0);
        chk(sck == 1'b0 && mosi == 1'b1, "R1 R10 reset lines", {sck, mosi}, 1);

        // Mode 0, fastest divider.
        tx_en = 1; rx_en = 1; div_val = 0;
        frame(8'hA5, 8'h3C); wait_idle();
        // Mode 1.
        cpha = 1; div_val = 2;
        frame(8'h81, 8'hC3); wait_idle();
        // Mode 2, LSB first.
        cpol = 1; cpha = 0; lsb_first = 1; div_val = 1;
        frame(8'h1E, 8'h96); wait_idle();
        @(negedge clk); chk(sck == 1'b1, "R1 idle high", sck, 1);
        // Mode 3.
        cpha = 1; lsb_first = 0; div_val = 4;
        frame(8'h5A, 8'h0F); wait_idle();
        // R9: read acknowledge clears the flag.
        @(negedge clk); rd_stb = 1; @(negedge clk); rd_stb = 0;
        chk(!rx_done, "R9 read clears", rx_done, 0);
        // R7: write during a frame is ignored.
        cpol = 0; cpha = 0; div_val = 3;
        frame(8'hC6, 8'h71);
        repeat (10) @(negedge clk);
        wr_stb = 1; wr_data = 8'h00; @(negedge clk); wr_stb = 0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(!busy && q.size() == 0, "R7 no extra frame", busy, 0);
        // R8: receiver off keeps rd_data and flag.
        rd_stb = 1; @(negedge clk); rd_stb = 0;
        rx_en = 0; lsb_first = 1;
        frame(8'h3B, 8'hE4); wait_idle();
        // R10: transmitter off sends 0xFF.
        tx_en = 0; rx_en = 1; cpha = 1;
        frame(8'h00, 8'h5D); wait_idle();
        // R11: disabled engine ignores writes.
        tx_en = 0; rx_en = 0; cpol = 1;
        @(negedge clk); wr_stb = 1; wr_data = 8'hAA; @(negedge clk); wr_stb = 0;
        repeat (5) @(negedge clk);
        chk(!busy, "R11 disabled write ignored", busy, 0);
        chk(sck == 1'b1, "R1 R11 disabled idle level", sck, 1);
        // R2: maximum divider.
        tx_en = 1; rx_en = 1; cpol = 0; cpha = 0; lsb_first = 0; div_val = 12'hFFF;
        frame(8'h69, 8'hB2); wait_idle();
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R3 all frames seen", q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule